// File: doc/BRIEF.md
# Packet Receive Link-Side Checker

This block sits on the link-layer side of a 32-bit packet receive bus. The physical-layer side feeds it words tagged with start, end, error, modulo and parity qualifiers. The block drives the active-low read request from a local readiness input, so downstream logic can pause the flow whenever it cannot take data. It looks at a word and its qualifiers only on cycles when the valid strobe is high.

Each accepted word goes out one cycle later on a registered byte stream. That stream carries the data, start and end markers, and byte enables decoded from the modulo field. At the same time the block checks the framing and parity rules of the bus. Every packet closes with a one-cycle status pulse that says whether the packet is good or must be discarded, and gives a code for the first rule it broke. Words that arrive outside a packet are dropped and reported. A start that arrives inside an open packet closes that packet as bad.

Top module: `pkt_rx_link_checker`

## Requirements
- R1: `rx_rd_en_n` is the inverse of `sink_ready` in the same cycle, whatever the other inputs are.
- R2: A cycle with `rx_valid` low has no effect: no output word and no status pulse follow, whatever data or qualifiers are present.
- R3: An accepted word (`rx_valid` high while a packet is open, or carrying start) appears on `out_data`, `out_sop` and `out_eop` with `out_valid` high in the cycle after it is sampled.
- R4: On an end word `out_be` follows `rx_mod`: 00 gives 1111, 01 gives 1110, 10 gives 1100, 11 gives 1000. Bit 3 enables `data[31:24]`. Every non-end word gives 1111.
- R5: With `cfg_odd_parity` = 0 the parity bit must equal the XOR of the 32 data bits. With 1 it must equal the inverse. A mismatch marks the packet bad with cause 4.
- R6: An end word yields a status pulse (`st_valid`) in the same cycle as its output word. A packet with no violation reports `st_good` = 1 and `st_cause` = 0.
- R7: An error flag on the end word marks the packet bad with cause 3.
- R8: An error flag on a word without end marks the packet bad with cause 5.
- R9: A nonzero modulo on a word without end marks the packet bad with cause 6.
- R10: A valid word without start while no packet is open is dropped (no `out_valid`). It raises a status pulse with `st_good` = 0 and cause 1.
- R11: A start while a packet is open raises a status pulse with `st_good` = 0 and cause 2 for the old packet. The word is forwarded with `out_sop` = 1 and opens a fresh packet.
- R12: A packet reports the first violation it met. Within one word, parity (4) beats an error flag (3 or 5), which beats a nonzero modulo (6).
- R13: While `rst_n` is low and after it, all outputs except `rx_rd_en_n` are 0 and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_odd_parity | input | 1 | 1 selects odd parity, 0 even |
| sink_ready | input | 1 | Downstream can accept data |
| rx_rd_en_n | output | 1 | Active-low read request to the physical side |
| rx_valid | input | 1 | Word and qualifiers are valid |
| rx_data | input | 32 | Packet word, first byte in bits 31:24 |
| rx_sop | input | 1 | Word starts a packet |
| rx_eop | input | 1 | Word ends a packet |
| rx_err | input | 1 | Packet is aborted (valid with end) |
| rx_mod | input | 2 | Count of empty low bytes on the end word |
| rx_par | input | 1 | Parity over `rx_data` |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | 32 | Forwarded word |
| out_be | output | 4 | Byte enables, bit 3 for bits 31:24 |
| out_sop | output | 1 | Forwarded word starts a packet |
| out_eop | output | 1 | Forwarded word ends a packet |
| st_valid | output | 1 | One-cycle packet status pulse |
| st_good | output | 1 | Packet may be kept |
| st_cause | output | 3 | First violation code, 0 when good |

## Verification
The bench goes after the cases where bookkeeping between words goes wrong. One is a start inside an open packet: a faulty design would merge the two packets or lose the old packet's bad status. Another is a word with no open packet: if it were forwarded instead of dropped, stray data would enter the stream. The bench also runs all four modulo values and both parity senses, where a flipped sense or a reversed byte order shows up at once in `st_cause` or `out_be`. Packets with two violations check that the first cause is kept and not overwritten by a later one.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_NO_START = 3'd1,
        CAUSE_NO_END   = 3'd2,
        CAUSE_ERR_FLAG = 3'd3,
        CAUSE_PARITY   = 3'd4,
        CAUSE_STRAY    = 3'd5,
        CAUSE_BAD_MOD  = 3'd6
    } cause_e;

endpackage

// File: rtl/pkt_rx_parity.sv
module pkt_rx_parity #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_in,
    input  logic              odd_mode,
    output logic              mismatch
);
    localparam int NBYTES = DATA_W / BYTE_W;

    logic [NBYTES-1:0] lane_par;

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_lane
            assign lane_par[g] = ^data[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // even: parity bit equals XOR of data; odd: its inverse
    assign mismatch = par_in != ((^lane_par) ^ odd_mode);
endmodule

// File: rtl/pkt_rx_be_decode.sv
module pkt_rx_be_decode #(
    parameter int NBYTES = 4,
    parameter int MOD_W  = 2
) (
    input  logic [MOD_W-1:0]  mod,
    input  logic              last,
    output logic [NBYTES-1:0] be
);
    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_be
            // lane g (MSB lane = NBYTES-1) carries data unless trimmed by mod
            assign be[g] = !last || ((MOD_W+1)'(g) >= {1'b0, mod});
        end
    endgenerate
endmodule

// File: rtl/pkt_rx_frame.sv
module pkt_rx_frame
    import pkt_rx_pkg::*;
#(
    parameter int MOD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             sop,
    input  logic             eop,
    input  logic             err,
    input  logic [MOD_W-1:0] mod,
    input  logic             par_bad,
    output logic             fwd,
    output logic             st_fire,
    output logic             st_ok,
    output cause_e           st_code
);
    typedef struct packed {
        logic   open;
        cause_e cause;
    } frame_t;

    frame_t frame_d, frame_q;
    cause_e word_cause;
    cause_e base_cause;
    cause_e acc_cause;

    always_comb begin
        if (par_bad)                 word_cause = CAUSE_PARITY;
        else if (err && eop)         word_cause = CAUSE_ERR_FLAG;
        else if (err)                word_cause = CAUSE_STRAY;
        else if (mod != '0 && !eop)  word_cause = CAUSE_BAD_MOD;
        else                         word_cause = CAUSE_NONE;
    end

    always_comb begin
        frame_d    = frame_q;
        fwd        = 1'b0;
        st_fire    = 1'b0;
        st_ok      = 1'b0;
        st_code    = CAUSE_NONE;
        base_cause = sop ? CAUSE_NONE : frame_q.cause;
        acc_cause  = (base_cause != CAUSE_NONE) ? base_cause : word_cause;

        if (valid) begin
            if (!frame_q.open && !sop) begin
                st_fire = 1'b1;
                st_code = CAUSE_NO_START;
            end else begin
                fwd = 1'b1;
                if (sop && frame_q.open) begin
                    st_fire = 1'b1;
                    st_code = CAUSE_NO_END;
                end else if (eop) begin
                    st_fire = 1'b1;
                    st_ok   = (acc_cause == CAUSE_NONE);
                    st_code = acc_cause;
                end
                if (eop) begin
                    frame_d.open  = 1'b0;
                    frame_d.cause = CAUSE_NONE;
                end else begin
                    frame_d.open  = 1'b1;
                    frame_d.cause = acc_cause;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q.open  <= 1'b0;
            frame_q.cause <= CAUSE_NONE;
        end else begin
            frame_q <= frame_d;
        end
    end
endmodule

// File: rtl/pkt_rx_link_checker.sv
module pkt_rx_link_checker
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int MOD_W  = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_odd_parity,
    input  logic                sink_ready,
    output logic                rx_rd_en_n,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_sop,
    input  logic                rx_eop,
    input  logic                rx_err,
    input  logic [MOD_W-1:0]    rx_mod,
    input  logic                rx_par,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic [NBYTES-1:0]   out_be,
    output logic                out_sop,
    output logic                out_eop,
    output logic                st_valid,
    output logic                st_good,
    output logic [CAUSE_W-1:0]  st_cause
);
    typedef struct packed {
        logic                ov;
        logic [DATA_W-1:0]   data;
        logic [NBYTES-1:0]   be;
        logic                sop;
        logic                eop;
        logic                sv;
        logic                good;
        logic [CAUSE_W-1:0]  cause;
    } out_t;

    out_t out_d, out_q;

    logic              par_bad;
    logic [NBYTES-1:0] be_w;
    logic              fwd, st_fire, st_ok;
    cause_e            st_code;

    assign rx_rd_en_n = !sink_ready;

    pkt_rx_parity #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_parity (
        .data(rx_data), .par_in(rx_par), .odd_mode(cfg_odd_parity), .mismatch(par_bad)
    );

    pkt_rx_be_decode #(.NBYTES(NBYTES), .MOD_W(MOD_W)) u_be (
        .mod(rx_mod), .last(rx_eop), .be(be_w)
    );

    pkt_rx_frame #(.MOD_W(MOD_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sop(rx_sop), .eop(rx_eop),
        .err(rx_err), .mod(rx_mod), .par_bad(par_bad),
        .fwd(fwd), .st_fire(st_fire), .st_ok(st_ok), .st_code(st_code)
    );

    always_comb begin
        out_d       = '0;
        out_d.ov    = fwd;
        out_d.sv    = st_fire;
        out_d.good  = st_fire && st_ok;
        out_d.cause = st_fire ? st_code : CAUSE_NONE;
        if (fwd) begin
            out_d.data = rx_data;
            out_d.be   = be_w;
            out_d.sop  = rx_sop;
            out_d.eop  = rx_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.ov;
    assign out_data  = out_q.data;
    assign out_be    = out_q.be;
    assign out_sop   = out_q.sop;
    assign out_eop   = out_q.eop;
    assign st_valid  = out_q.sv;
    assign st_good   = out_q.good;
    assign st_cause  = out_q.cause;
endmodule

// File: rtl/pkt_rx_link_checker_sva.sv
module pkt_rx_link_checker_sva #(
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              out_valid,
    input logic              out_eop,
    input logic [NBYTES-1:0] out_be,
    input logic              st_valid,
    input logic              st_good,
    input logic [2:0]        st_cause
);
    a_r2_no_output_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || st_valid) |-> $past(rx_valid));

    a_r4_full_word_unless_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_be == {NBYTES{1'b1}}));

    a_r4_top_lane_always_on: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_be[NBYTES-1]);

    a_r6_good_has_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_good) |-> (st_cause == 3'd0));

    a_r12_bad_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_good) |-> (st_cause != 3'd0));

    a_r13_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> (!st_good && st_cause == 3'd0));
endmodule

bind pkt_rx_link_checker pkt_rx_link_checker_sva #(.NBYTES(NBYTES)) u_sva (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .out_valid(out_valid),
    .out_eop(out_eop), .out_be(out_be), .st_valid(st_valid),
    .st_good(st_good), .st_cause(st_cause)
);

// File: tb/test_pkt_rx_link_checker.sv
module test_pkt_rx_link_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_odd_parity = 1'b0;
    logic        sink_ready = 1'b0;
    logic        rx_rd_en_n;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0, rx_par = 1'b0;
    logic [1:0]  rx_mod = '0;
    logic        out_valid, out_sop, out_eop, st_valid, st_good;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic [2:0]  st_cause;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pkt_rx_link_checker i_pkt_rx_link_checker (.*);

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one valid word at negedge, return at next negedge (outputs updated)
    task automatic word(input logic sop, input logic eop, input logic err,
                        input logic [1:0] mod, input logic [31:0] d, input logic par_flip);
        rx_valid = 1'b1; rx_sop = sop; rx_eop = eop; rx_err = err;
        rx_mod = mod; rx_data = d;
        rx_par = (^d) ^ cfg_odd_parity ^ par_flip;
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0; rx_mod = '0;
    endtask

    task automatic expect_out(input string req, input logic v, input logic [31:0] d,
                              input logic [3:0] be, input logic s, input logic e);
        check(req, "out_valid", 32'(out_valid), 32'(v));
        if (v) begin
            check(req, "out_data", out_data, d);
            check(req, "out_be", 32'(out_be), 32'(be));
            check(req, "out_sop", 32'(out_sop), 32'(s));
            check(req, "out_eop", 32'(out_eop), 32'(e));
        end
    endtask

    task automatic expect_st(input string req, input logic v, input logic g,
                             input logic [2:0] c);
        check(req, "st_valid", 32'(st_valid), 32'(v));
        if (v) begin
            check(req, "st_good", 32'(st_good), 32'(g));
            check(req, "st_cause", 32'(st_cause), 32'(c));
        end
    endtask

    task automatic t_reset_and_rden;
        // R13
        expect_out("R13", 1'b0, '0, '0, 1'b0, 1'b0);
        expect_st("R13", 1'b0, 1'b0, 3'd0);
        check("R13", "st_good", 32'(st_good), 0);
        // R1
        sink_ready = 1'b1; #1;
        check("R1", "rd_en_n", 32'(rx_rd_en_n), 0);
        sink_ready = 1'b0; rx_valid = 1'b0; #1;
        check("R1", "rd_en_n", 32'(rx_rd_en_n), 1);
        sink_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clean_packet;
        word(1, 0, 0, 2'd0, 32'hA1B2C3D4, 0);
        expect_out("R3", 1, 32'hA1B2C3D4, 4'hF, 1, 0);
        expect_st("R6", 0, 0, 0);
        word(0, 0, 0, 2'd0, 32'h01020304, 0);
        expect_out("R3", 1, 32'h01020304, 4'hF, 0, 0);
        word(0, 1, 0, 2'd2, 32'hDEAD0000, 0);
        expect_out("R4", 1, 32'hDEAD0000, 4'hC, 0, 1);
        expect_st("R6", 1, 1, 0);
    endtask

    task automatic t_mod_sweep;
        logic [3:0] exp_be [4] = '{4'hF, 4'hE, 4'hC, 4'h8};
        for (int m = 0; m < 4; m++) begin
            word(1, 1, 0, 2'(m), 32'h11223344 + m, 0);
            expect_out("R4", 1, 32'h11223344 + m, exp_be[m], 1, 1);
            expect_st("R4", 1, 1, 0);
        end
    endtask

    task automatic t_parity;
        cfg_odd_parity = 1'b1;
        word(1, 1, 0, 2'd0, 32'h00000007, 0);
        expect_st("R5", 1, 1, 0);
        word(1, 0, 0, 2'd0, 32'h00000001, 0);
        word(0, 1, 0, 2'd0, 32'h00000003, 1);
        expect_st("R5", 1, 0, 3'd4);
        cfg_odd_parity = 1'b0;
        word(1, 1, 0, 2'd0, 32'h0F000000, 1);
        expect_st("R5", 1, 0, 3'd4);
    endtask

    task automatic t_err_flags;
        word(1, 0, 0, 2'd0, 32'h1, 0);
        word(0, 1, 1, 2'd1, 32'h2, 0);
        expect_st("R7", 1, 0, 3'd3);
        word(1, 0, 1, 2'd0, 32'h3, 0);
        expect_st("R8", 0, 0, 0);
        word(0, 1, 0, 2'd0, 32'h4, 0);
        expect_st("R8", 1, 0, 3'd5);
        word(1, 0, 0, 2'd3, 32'h5, 0);
        expect_out("R9", 1, 32'h5, 4'hF, 1, 0);
        word(0, 1, 0, 2'd0, 32'h6, 0);
        expect_st("R9", 1, 0, 3'd6);
    endtask

    task automatic t_framing;
        word(0, 0, 0, 2'd0, 32'hBAD0BAD0, 0);
        expect_out("R10", 0, '0, '0, 0, 0);
        expect_st("R10", 1, 0, 3'd1);
        word(1, 0, 0, 2'd0, 32'h10, 0);
        word(1, 0, 0, 2'd0, 32'h20, 0);
        expect_out("R11", 1, 32'h20, 4'hF, 1, 0);
        expect_st("R11", 1, 0, 3'd2);
        word(0, 1, 0, 2'd0, 32'h30, 0);
        expect_st("R11", 1, 1, 0);
    endtask

    task automatic t_priority;
        word(1, 0, 0, 2'd1, 32'h40, 0);
        word(0, 0, 0, 2'd0, 32'h41, 1);
        word(0, 1, 0, 2'd0, 32'h42, 0);
        expect_st("R12", 1, 0, 3'd6);
        word(1, 1, 1, 2'd0, 32'h43, 1);
        expect_st("R12", 1, 0, 3'd4);
        word(1, 0, 1, 2'd2, 32'h44, 0);
        word(0, 1, 0, 2'd0, 32'h45, 0);
        expect_st("R12", 1, 0, 3'd5);
    endtask

    task automatic t_idle_ignored;
        rx_valid = 1'b0; rx_sop = 1'b1; rx_eop = 1'b1; rx_err = 1'b1;
        rx_mod = 2'd3; rx_data = 32'hFFFFFFFF; rx_par = 1'b0;
        @(negedge clk);
        expect_out("R2", 0, '0, '0, 0, 0);
        expect_st("R2", 0, 0, 0);
        @(negedge clk);
        rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0; rx_mod = '0;
        word(0, 1, 0, 2'd0, 32'h50, 0);
        expect_st("R2", 1, 0, 3'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_and_rden();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean_packet();
        t_mod_sweep();
        t_parity();
        t_err_flags();
        t_framing();
        t_priority();
        t_idle_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule